// File: doc/BRIEF.md
# Parallel Camera Pixel Receiver

This block captures an 8-bit parallel camera bus (pixel clock, line sync, frame sync, data) in the system clock domain. It turns the sampled bytes into a stream of 16-bit words, each marked by a one-cycle valid pulse. Two-byte formats join two bus cycles into one word, in either byte order. One-byte formats put each byte in the low half of the word. The first word of a frame carries a start-of-frame flag. The last word of a line carries an end-of-line flag.

The configuration inputs are static while capture runs. They are an enable, a format code, a byte-order swap bit, polarity bits for the two sync lines and the pixel clock, and a select for embedded synchronisation. With embedded synchronisation selected, the frame and line windows come from an external code detector as active-high levels, and the two sync pins are ignored. The pixel clock is oversampled: one sampling edge of the synchronised pixel clock is one bus cycle. For this to work the system clock must run at least twice as fast as the pixel clock.

Top module: `cam_par_rx`

## Requirements
- R1: After reset, out_valid, out_sof and out_eol are low.
- R2: Format code 0x22 or 0x1E joins two bytes per word. Code 0x2A, 0x4A or 0x5A gives one word per byte, with the byte in out_data[7:0] and out_data[15:8] zero. Any other code gives no words.
- R3: For two-byte formats with swap low, the first byte of a pair is out_data[15:8] and the second is out_data[7:0]. With swap high the first byte is out_data[7:0] and the second is out_data[15:8].
- R4: With vs_pol high, the frame window is vsync high; with vs_pol low, it is vsync low. hs_pol sets the level of hsync that marks the line window in the same way.
- R5: With pclk_pol high, bytes are sampled on rising pixel-clock edges. With it low, they are sampled on falling edges.
- R6: No word is produced while en is low. Clearing en in the middle of a frame stops output at once for the rest of that frame.
- R7: Capture begins only at a frame start seen while en is high. Setting en in the middle of a frame produces no words until the next frame.
- R8: out_sof is high on the first word of each captured frame and low on every other word.
- R9: Outside byte-stream mode, out_eol is high on the last word of each line. The byte pairing restarts at every line, so an odd byte left at the end of a line is dropped.
- R10: In byte-stream mode (0x5A), every byte sampled inside the frame window is passed on, whatever the line sync does, and out_eol is never set.
- R11: With emb_sel high, emb_frame and emb_line (active high) give the frame and line windows, and vsync, hsync and their polarity bits have no effect.
- R12: out_valid is high for one cycle per word and is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Capture enable |
| vs_pol | input | 1 | Frame sync active level |
| hs_pol | input | 1 | Line sync active level |
| pclk_pol | input | 1 | 1 = sample on the rising pixel-clock edge, 0 = on the falling edge |
| emb_sel | input | 1 | Use the code-detector windows instead of the sync pins |
| fmt | input | 8 | Format code |
| swap | input | 1 | Byte order of two-byte pixels |
| pclk | input | 1 | Camera pixel clock |
| hsync | input | 1 | Line sync pin |
| vsync | input | 1 | Frame sync pin |
| pix_d | input | 8 | Camera data bus |
| emb_frame | input | 1 | Frame window from the code detector |
| emb_line | input | 1 | Line window from the code detector |
| out_valid | output | 1 | Word strobe |
| out_data | output | 16 | Output word |
| out_sof | output | 1 | First word of a frame |
| out_eol | output | 1 | Last word of a line |

## Verification
The assertions check on every cycle that the output is silent while enable is low, that valid strobes never come back to back, that the upper byte is zero in one-byte formats, that byte-stream mode never flags an end of line, and that a start-of-frame flag never appears without a word. Byte order, the effect of each polarity setting, the dropped odd byte, the wait for a frame start after a mid-frame enable, and the switch to code-detector framing can only be shown by the bench's frame scenarios, which compare every emitted word and its flags against frames built from the requirements.

// File: rtl/cam_par_rx.sv
module cam_par_rx #(
  parameter int BW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic            vs_pol,
  input  logic            hs_pol,
  input  logic            pclk_pol,
  input  logic            emb_sel,
  input  logic [7:0]      fmt,
  input  logic            swap,
  input  logic            pclk,
  input  logic            hsync,
  input  logic            vsync,
  input  logic [BW-1:0]   pix_d,
  input  logic            emb_frame,
  input  logic            emb_line,
  output logic            out_valid,
  output logic [2*BW-1:0] out_data,
  output logic            out_sof,
  output logic            out_eol
);
  localparam int OW = 2 * BW;
  localparam logic [7:0] F_YUV  = 8'h1E;
  localparam logic [7:0] F_RGB  = 8'h22;
  localparam logic [7:0] F_RAW  = 8'h2A;
  localparam logic [7:0] F_GREY = 8'h4A;
  localparam logic [7:0] F_BSTR = 8'h5A;

  logic s_pclk, p_pclk, s_hs, s_vs, s_ef, s_el;
  logic [BW-1:0] s_d;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s_pclk <= 1'b0; p_pclk <= 1'b0; s_hs <= 1'b0; s_vs <= 1'b0;
      s_ef <= 1'b0; s_el <= 1'b0; s_d <= '0;
    end else begin
      s_pclk <= pclk; p_pclk <= s_pclk; s_hs <= hsync; s_vs <= vsync;
      s_ef <= emb_frame; s_el <= emb_line; s_d <= pix_d;
    end

  logic ev, frame_act, line_act, two, one, bstr, span, sof, go, take;
  logic word_done, flush, emit;
  logic f_prev, run, phase, sof_pend, hv, hsof;
  logic [BW-1:0] b0;
  logic [OW-1:0] hd, word;

  assign ev        = pclk_pol ? (s_pclk & ~p_pclk) : (~s_pclk & p_pclk);
  assign frame_act = emb_sel ? s_ef : ~(s_vs ^ vs_pol);
  assign line_act  = emb_sel ? s_el : ~(s_hs ^ hs_pol);
  assign two       = (fmt == F_YUV) || (fmt == F_RGB);
  assign bstr      = (fmt == F_BSTR);
  assign one       = (fmt == F_RAW) || (fmt == F_GREY) || bstr;
  assign span      = frame_act & (bstr | line_act);
  assign sof       = frame_act & ~f_prev;
  assign go        = en & (run | sof);
  assign take      = ev & go & span & (two | one);
  assign word_done = take & (one | phase);
  assign flush     = ev & en & hv & ~span;
  assign emit      = flush | (word_done & hv);
  assign word      = one  ? {{BW{1'b0}}, s_d} :
                     swap ? {s_d, b0} : {b0, s_d};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      f_prev <= 1'b0; run <= 1'b0; phase <= 1'b0; sof_pend <= 1'b0;
      hv <= 1'b0; hsof <= 1'b0; b0 <= '0; hd <= '0;
      out_valid <= 1'b0; out_data <= '0; out_sof <= 1'b0; out_eol <= 1'b0;
    end else begin
      if (ev) f_prev <= frame_act;
      out_valid <= emit & en;
      out_sof   <= emit & en & hsof;
      out_eol   <= flush & ~bstr;
      if (emit) out_data <= hd;
      if (!en) begin
        run <= 1'b0; phase <= 1'b0; sof_pend <= 1'b0; hv <= 1'b0;
      end else if (ev) begin
        if (sof) begin
          run <= 1'b1;
          sof_pend <= 1'b1;
        end
        if (!span) phase <= 1'b0;
        else if (take && two) phase <= ~phase;
        if (take && two && !phase) b0 <= s_d;
        if (word_done) begin
          hv <= 1'b1; hd <= word; hsof <= sof_pend | sof; sof_pend <= 1'b0;
        end else if (flush) hv <= 1'b0;
      end
    end
endmodule

// File: rtl/cam_par_rx_chk.sv
module cam_par_rx_chk #(
  parameter int BW = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            en,
  input logic [7:0]      fmt,
  input logic            out_valid,
  input logic [2*BW-1:0] out_data,
  input logic            out_sof,
  input logic            out_eol
);
  logic one_byte;
  assign one_byte = (fmt == 8'h2A) || (fmt == 8'h4A) || (fmt == 8'h5A);

  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !out_valid); // R6
  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid); // R12
  AST_BYTE_HI_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && one_byte) |-> (out_data[2*BW-1:BW] == '0)); // R2
  AST_STREAM_NO_EOL: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && fmt == 8'h5A) |-> !out_eol); // R10
  AST_SOF_WITH_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    out_sof |-> out_valid); // R8
endmodule

bind cam_par_rx cam_par_rx_chk #(.BW(BW)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .fmt(fmt), .out_valid(out_valid),
  .out_data(out_data), .out_sof(out_sof), .out_eol(out_eol)
);

// File: tb/cam_par_rx_bench.sv
module cam_par_rx_bench;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0, vs_pol = 1'b1, hs_pol = 1'b1, pclk_pol = 1'b1, emb_sel = 1'b0;
  logic [7:0] fmt = 8'h22;
  logic swap = 1'b0;
  logic pclk = 1'b0, hsync = 1'b0, vsync = 1'b0, emb_frame = 1'b0, emb_line = 1'b0;
  logic [7:0] pix_d = 8'h00;
  logic out_valid, out_sof, out_eol;
  logic [15:0] out_data;

  int checks = 0, errors = 0;
  logic [7:0] bctr = 8'h11;
  logic [17:0] expq[$];
  string tagq[$];
  bit prev_v = 1'b0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  cam_par_rx u_cam_par_rx (
    .clk(clk), .rst_n(rst_n), .en(en), .vs_pol(vs_pol), .hs_pol(hs_pol),
    .pclk_pol(pclk_pol), .emb_sel(emb_sel), .fmt(fmt), .swap(swap), .pclk(pclk),
    .hsync(hsync), .vsync(vsync), .pix_d(pix_d), .emb_frame(emb_frame),
    .emb_line(emb_line), .out_valid(out_valid), .out_data(out_data),
    .out_sof(out_sof), .out_eol(out_eol)
  );

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      checks++;
      if (prev_v) begin
        errors++;
        $display("FAIL R12 back-to-back valid: actual 1 expected 0");
      end
      checks++;
      if (expq.size() == 0) begin
        errors++;
        $display("FAIL R2 R6 R7 unexpected word: actual %h expected none", out_data);
      end else begin
        logic [17:0] e;
        string t;
        e = expq.pop_front();
        t = tagq.pop_front();
        if ({out_data, out_sof, out_eol} !== e) begin
          errors++;
          $display("FAIL %s word/sof/eol: actual %h/%b/%b expected %h/%b/%b",
                   t, out_data, out_sof, out_eol, e[17:2], e[1], e[0]);
        end
      end
    end
    prev_v = out_valid;
  end

  task automatic push(input logic [15:0] d, input bit s, input bit l, input string t);
    expq.push_back({d, s, l});
    tagq.push_back(t);
  endtask

  task automatic ev(input bit fa, input bit la);
    @(negedge clk);
    pclk = ~pclk_pol;
    pix_d = bctr;
    bctr = bctr + 8'd1;
    if (emb_sel) begin
      emb_frame = fa; emb_line = la; vsync = ~vs_pol; hsync = ~hs_pol;
    end else begin
      emb_frame = 1'b0; emb_line = 1'b0;
      vsync = fa ? vs_pol : ~vs_pol;
      hsync = la ? hs_pol : ~hs_pol;
    end
    repeat (3) @(negedge clk);
    pclk = pclk_pol;
    repeat (4) @(negedge clk);
  endtask

  task automatic cfg(input logic [7:0] f, input bit sw, input bit vp, input bit hp,
                     input bit pp, input bit es);
    @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    fmt = f; swap = sw; vs_pol = vp; hs_pol = hp; pclk_pol = pp; emb_sel = es;
    ev(0, 0); ev(0, 0);
    @(negedge clk);
    en = 1'b1;
    ev(0, 0);
  endtask

  task automatic send_frame(input int nl, input int nb, input int en_line,
                            input int dis_line, input string t);
    int start, np;
    bit first, two, one, bs;
    logic [7:0] b1, b2;
    start = int'(bctr);
    first = 1'b1;
    two = (fmt == 8'h1E) || (fmt == 8'h22);
    bs  = (fmt == 8'h5A);
    one = (fmt == 8'h2A) || (fmt == 8'h4A);
    if (en_line < 0) begin
      if (bs) begin
        for (int e = 0; e < 2 + nl * (nb + 2); e++) begin
          push({8'h00, 8'(start + e)}, e == 0, 1'b0, t);
        end
      end else begin
        for (int i = 0; i < nl; i++) begin
          if (dis_line < 0 || i < dis_line) begin
            if (two) begin
              np = nb / 2;
              for (int k = 0; k < np; k++) begin
                b1 = 8'(start + 2 + i * (nb + 2) + 2 * k);
                b2 = b1 + 8'd1;
                push(swap ? {b2, b1} : {b1, b2}, first, k == np - 1, t);
                first = 1'b0;
              end
            end else if (one) begin
              for (int j = 0; j < nb; j++) begin
                push({8'h00, 8'(start + 2 + i * (nb + 2) + j)}, first, j == nb - 1, t);
                first = 1'b0;
              end
            end
          end
        end
      end
    end
    ev(1, 0); ev(1, 0);
    for (int i = 0; i < nl; i++) begin
      if (i == en_line) begin @(negedge clk); en = 1'b1; end
      if (i == dis_line) begin @(negedge clk); en = 1'b0; end
      for (int j = 0; j < nb; j++) ev(1, 1);
      ev(1, 0); ev(1, 0);
    end
    ev(0, 0); ev(0, 0);
    repeat (20) @(negedge clk);
    checks++;
    if (expq.size() != 0) begin
      errors++;
      $display("FAIL %s words missing: actual %0d left expected 0", t, expq.size());
      expq.delete();
      tagq.delete();
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || out_sof !== 1'b0 || out_eol !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset outputs: actual %b%b%b expected 000", out_valid, out_sof, out_eol);
    end
    cfg(8'h22, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0);
    send_frame(3, 6, -1, -1, "R2 R3 R8 R9 two-byte order");
    send_frame(2, 4, -1, -1, "R8 second frame sof");
    cfg(8'h1E, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0);
    send_frame(2, 5, -1, -1, "R3 R9 swapped odd line");
    cfg(8'h2A, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    send_frame(2, 4, -1, -1, "R4 R5 R2 inverted polarity");
    cfg(8'h4A, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0);
    send_frame(1, 3, -1, -1, "R2 R4 grey");
    cfg(8'h5A, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
    send_frame(2, 3, -1, -1, "R10 byte stream");
    cfg(8'h10, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0);
    send_frame(2, 4, -1, -1, "R2 unknown code");
    cfg(8'h22, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1);
    send_frame(2, 4, -1, -1, "R11 embedded framing");
    cfg(8'h22, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0);
    @(negedge clk);
    en = 1'b0;
    send_frame(3, 4, 1, -1, "R7 late enable");
    send_frame(2, 4, -1, -1, "R7 next frame");
    send_frame(3, 4, -1, 1, "R6 mid-frame disable");
    @(negedge clk);
    en = 1'b1;
    send_frame(1, 4, -1, -1, "R6 R7 re-enable");
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule